// File: doc/BRIEF.md
# External Bus Strobe Generator

This block times the external multiplexed bus of an 8-bit microcontroller core. It divides the oscillator clock into 12-clock machine cycles. In each cycle it produces the address-latch strobe (`ale`, active high) and the program-read strobe (`psen_n`, active low). It also chooses the byte that the high address port presents. The core's sequencer reports four things for each machine cycle: whether the cycle moves external data, whether that move uses a 16-bit pointer, whether it reads a code constant, and the current pin and control levels. The block latches these reports at the cycle boundary and keeps the strobes for that cycle fixed to them.

A raw reset pin is qualified before it has any effect. It must stay high for two whole machine cycles (24 clock edges). Only then does the block assert the internal reset `sys_rst`, which holds the cycle counter at its start and parks both strobes.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: A machine cycle is 12 clocks long. `cyc_first` is high during count 0 of each cycle and low during counts 1 to 11.
- R2: In a cycle with no external data move, and with the latch strobe enabled, `ale` is high during counts 0, 1, 6 and 7 and low during all other counts.
- R3: In an external data move cycle, the latch pulse at counts 6 and 7 is dropped. The pulse at counts 0 and 1 is kept.
- R4: With `ale_off` = 1 and `ea_n` = 1, `ale` stays high for the whole cycle, unless the cycle is a data move or a code-constant read. Those cycles pulse as in R2 and R3.
- R5: With `ea_n` = 0 (code fetched externally), `ale_off` has no effect, and `ale` pulses as in R2 and R3.
- R6: With `ea_n` = 0 and no data move, `psen_n` is low during counts 3 to 5 and 9 to 11, and high during all other counts. It is never low while `ale` is high.
- R7: With `ea_n` = 0 in an external data move cycle, `psen_n` stays high for the whole cycle.
- R8: With `ea_n` = 1, `psen_n` stays high.
- R9: `hi_port` equals `p2_sfr` in a data move cycle with `xdata_wide` = 0. In every other cycle it equals `addr_hi`. The data inputs pass through in the same clock period.
- R10: The inputs `ea_n`, `ale_off`, `xdata_cyc`, `code_rd_cyc` and `xdata_wide` are sampled only at the clock edge that starts count 0. Changes at other times have no effect until the next cycle.
- R11: `sys_rst` goes high at the 24th consecutive edge at which `rst_pin` is high. While `sys_rst` is high, `ale` = 1, `psen_n` = 1 and `cyc_first` = 0. The first edge with `rst_pin` low clears `sys_rst`, and the clock period that follows is count 0 of a new cycle.
- R12: If `rst_pin` is high for fewer than 24 consecutive edges, `sys_rst` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset pin, active high |
| ea_n | input | 1 | External-access pin level; 0 means code is fetched externally |
| ale_off | input | 1 | Control bit that parks the latch strobe |
| xdata_cyc | input | 1 | Sequencer flag: this cycle moves external data |
| code_rd_cyc | input | 1 | Sequencer flag: this cycle reads a code constant |
| xdata_wide | input | 1 | Data move uses the 16-bit pointer (1) or an 8-bit register (0) |
| addr_hi | input | 8 | High address byte from the core |
| p2_sfr | input | 8 | Contents of the high port's output register |
| sys_rst | output | 1 | Qualified internal reset |
| cyc_first | output | 1 | High during count 0 of every machine cycle |
| ale | output | 1 | Address-latch strobe |
| psen_n | output | 1 | Program-read strobe, active low |
| hi_port | output | 8 | Byte driven onto the high address port |

## Verification
The counter and the latched cycle flags are both registers, so every strobe and `hi_port` value for count k holds during the k-th clock period after the boundary edge. The bench drives the flags half a period before that edge and samples 1 ns after each following rising edge, comparing all twelve counts. `sys_rst` changes at the same edge that brings the qualifying sample, so it is read 1 ns after that edge. During count 4 the bench inverts every flag and still expects the old behaviour, which checks R10 in every cycle.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

    localparam int MC_CLOCKS   = 12;
    localparam int RST_CYCLES  = 2;
    localparam int LATCH_WIDTH = 2;
    localparam int READ_WIDTH  = 3;
    localparam int BYTE_W      = 8;

    typedef struct packed {
        logic ext_exec;
        logic ale_off;
        logic xdata;
        logic code_rd;
        logic wide_ptr;
    } cyc_ctx_t;

    typedef enum logic {
        HI_FROM_ADDR = 1'b0,
        HI_FROM_SFR  = 1'b1
    } hi_src_e;

    function automatic logic in_window(int ph, int start, int width);
        return (ph >= start) && (ph < start + width);
    endfunction

endpackage

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
    parameter int HOLD = 24
) (
    input  logic clk,
    input  logic rst_pin,
    output logic sys_rst
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (!rst_pin)
            hold_cnt <= '0;
        else if (hold_cnt != CW'(HOLD))
            hold_cnt <= hold_cnt + 1'b1;
    end

    assign sys_rst = (hold_cnt == CW'(HOLD));

endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
    import strobe_pkg::*;
#(
    parameter int MC_LEN = MC_CLOCKS,
    localparam int PH_W  = $clog2(MC_LEN)
) (
    input  logic            clk,
    input  logic            sys_rst,
    input  logic            ea_n,
    input  logic            ale_off,
    input  logic            xdata_cyc,
    input  logic            code_rd_cyc,
    input  logic            xdata_wide,
    output logic [PH_W-1:0] phase,
    output cyc_ctx_t        ctx,
    output logic            cyc_first
);
    localparam logic [PH_W-1:0] LAST = PH_W'(MC_LEN - 1);

    logic boundary;
    assign boundary = sys_rst || (phase == LAST);

    always_ff @(posedge clk) begin
        if (sys_rst)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (boundary) begin
            ctx.ext_exec <= ~ea_n;
            ctx.ale_off  <= ale_off;
            ctx.xdata    <= xdata_cyc;
            ctx.code_rd  <= code_rd_cyc;
            ctx.wide_ptr <= xdata_wide;
        end
    end

    assign cyc_first = (phase == '0) && !sys_rst;

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (phase == LAST) |=> (phase == '0) && cyc_first);

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (sys_rst)
        phase <= LAST);

    // R10
    ctx_hold_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (phase != LAST) |=> $stable(ctx));

endmodule

// File: rtl/bus_decode.sv
module bus_decode
    import strobe_pkg::*;
#(
    parameter int MC_LEN  = MC_CLOCKS,
    parameter int LATCH_W = LATCH_WIDTH,
    parameter int READ_W  = READ_WIDTH,
    parameter int DW      = BYTE_W,
    localparam int PH_W   = $clog2(MC_LEN),
    localparam int HALF   = MC_LEN / 2
) (
    input  logic            clk,
    input  logic            sys_rst,
    input  logic [PH_W-1:0] phase,
    input  cyc_ctx_t        ctx,
    input  logic [DW-1:0]   addr_hi,
    input  logic [DW-1:0]   p2_sfr,
    output logic            ale,
    output logic            psen_n,
    output logic [DW-1:0]   hi_port
);
    logic [1:0] latch_hit;
    logic [1:0] read_hit;

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam int BASE = h * HALF;
        assign latch_hit[h] = in_window(int'(phase), BASE, LATCH_W);
        assign read_hit[h]  = in_window(int'(phase), BASE + HALF - READ_W, READ_W);
    end

    logic latch_pulse, latch_live, read_live;
    hi_src_e hi_src;

    assign latch_pulse = latch_hit[0] | (latch_hit[1] & ~ctx.xdata);
    assign latch_live  = ctx.ext_exec | ~ctx.ale_off | ctx.xdata | ctx.code_rd;
    assign read_live   = ctx.ext_exec & ~ctx.xdata;

    always_comb begin
        if (sys_rst) begin
            ale    = 1'b1;
            psen_n = 1'b1;
        end else begin
            ale    = latch_live ? latch_pulse : 1'b1;
            psen_n = ~(read_live & (read_hit[0] | read_hit[1]));
        end
    end

    assign hi_src  = (ctx.xdata && !ctx.wide_ptr) ? HI_FROM_SFR : HI_FROM_ADDR;
    assign hi_port = (hi_src == HI_FROM_SFR) ? p2_sfr : addr_hi;

    // R6
    rd_after_latch_chk: assert property (@(posedge clk) disable iff (sys_rst)
        !psen_n |-> !ale);

    // R8
    rd_idle_internal_chk: assert property (@(posedge clk) disable iff (sys_rst)
        !ctx.ext_exec |-> psen_n);

    // R7
    xdata_no_read_chk: assert property (@(posedge clk) disable iff (sys_rst)
        ctx.xdata |-> psen_n);

    // R3
    xdata_one_latch_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (ctx.xdata && phase == PH_W'(HALF)) |-> !ale);

    // R4
    ale_parked_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (ctx.ale_off && !ctx.ext_exec && !ctx.xdata && !ctx.code_rd) |-> ale);

    // R9
    hi_sfr_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (ctx.xdata && !ctx.wide_ptr) |-> (hi_port == p2_sfr));

endmodule

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen
    import strobe_pkg::*;
#(
    parameter int MC_LEN  = MC_CLOCKS,
    parameter int RST_MC  = RST_CYCLES,
    parameter int LATCH_W = LATCH_WIDTH,
    parameter int READ_W  = READ_WIDTH,
    parameter int DW      = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_pin,
    input  logic          ea_n,
    input  logic          ale_off,
    input  logic          xdata_cyc,
    input  logic          code_rd_cyc,
    input  logic          xdata_wide,
    input  logic [DW-1:0] addr_hi,
    input  logic [DW-1:0] p2_sfr,
    output logic          sys_rst,
    output logic          cyc_first,
    output logic          ale,
    output logic          psen_n,
    output logic [DW-1:0] hi_port
);
    localparam int PH_W = $clog2(MC_LEN);
    localparam int HOLD = RST_MC * MC_LEN;

    logic [PH_W-1:0] phase;
    cyc_ctx_t        ctx;

    rst_qualifier #(.HOLD(HOLD)) u_rst (
        .clk     (clk),
        .rst_pin (rst_pin),
        .sys_rst (sys_rst)
    );

    mc_sequencer #(.MC_LEN(MC_LEN)) u_seq (
        .clk         (clk),
        .sys_rst     (sys_rst),
        .ea_n        (ea_n),
        .ale_off     (ale_off),
        .xdata_cyc   (xdata_cyc),
        .code_rd_cyc (code_rd_cyc),
        .xdata_wide  (xdata_wide),
        .phase       (phase),
        .ctx         (ctx),
        .cyc_first   (cyc_first)
    );

    bus_decode #(
        .MC_LEN  (MC_LEN),
        .LATCH_W (LATCH_W),
        .READ_W  (READ_W),
        .DW      (DW)
    ) u_dec (
        .clk     (clk),
        .sys_rst (sys_rst),
        .phase   (phase),
        .ctx     (ctx),
        .addr_hi (addr_hi),
        .p2_sfr  (p2_sfr),
        .ale     (ale),
        .psen_n  (psen_n),
        .hi_port (hi_port)
    );

    // R11
    rst_parks_chk: assert property (@(posedge clk)
        sys_rst |-> (ale && psen_n && !cyc_first));

endmodule

// File: tb/test_ext_bus_strobe_gen.sv
module test_ext_bus_strobe_gen;

    typedef struct packed {
        logic       ea_n;
        logic       off;
        logic       xd;
        logic       crd;
        logic       wide;
        logic [7:0] ah;
        logic [7:0] p2;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA1, 8'h5C},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h12, 8'h34},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h7E, 8'h81},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hC3},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 8'hAA},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, 8'hF0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h99, 8'h66},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h21, 8'hDE},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hE4, 8'h1B},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h48, 8'hB7}
    };

    logic       clk = 1'b0;
    logic       rst_pin = 1'b0;
    logic       ea_n = 1'b1, ale_off = 1'b0, xdata_cyc = 1'b0;
    logic       code_rd_cyc = 1'b0, xdata_wide = 1'b0;
    logic [7:0] addr_hi = 8'h00, p2_sfr = 8'h00;
    logic       sys_rst, cyc_first, ale, psen_n;
    logic [7:0] hi_port;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ext_bus_strobe_gen i_ext_bus_strobe_gen (
        .clk         (clk),
        .rst_pin     (rst_pin),
        .ea_n        (ea_n),
        .ale_off     (ale_off),
        .xdata_cyc   (xdata_cyc),
        .code_rd_cyc (code_rd_cyc),
        .xdata_wide  (xdata_wide),
        .addr_hi     (addr_hi),
        .p2_sfr      (p2_sfr),
        .sys_rst     (sys_rst),
        .cyc_first   (cyc_first),
        .ale         (ale),
        .psen_n      (psen_n),
        .hi_port     (hi_port)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_flags(input vec_t v);
        ea_n        = v.ea_n;
        ale_off     = v.off;
        xdata_cyc   = v.xd;
        code_rd_cyc = v.crd;
        xdata_wide  = v.wide;
    endtask

    // Caller is at a falling edge inside the last count of the previous cycle.
    task automatic run_cycle(input vec_t v);
        logic en, pls, rd, e_ale, e_psen;
        logic [7:0] e_hi;
        drive_flags(v);
        addr_hi = v.ah;
        p2_sfr  = v.p2;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk); #1;
            en     = v.off ? (!v.ea_n || v.xd || v.crd) : 1'b1;   // R4 R5
            pls    = (k < 2) || (k >= 6 && k < 8 && !v.xd);        // R2 R3
            e_ale  = en ? pls : 1'b1;
            rd     = !v.ea_n && !v.xd && ((k >= 3 && k < 6) || k >= 9); // R6 R7 R8
            e_psen = !rd;
            e_hi   = (v.xd && !v.wide) ? v.p2 : v.ah;              // R9
            chk("R1 cyc_first", {7'b0, cyc_first}, {7'b0, k == 0});
            chk("R11 sys_rst released", {7'b0, sys_rst}, 8'h00);
            chk(v.xd ? "R3 ale" : (v.off ? (v.ea_n ? "R4 ale" : "R5 ale") : "R2 ale"),
                {7'b0, ale}, {7'b0, e_ale});
            chk(v.ea_n ? "R8 psen_n" : (v.xd ? "R7 psen_n" : "R6 psen_n"),
                {7'b0, psen_n}, {7'b0, e_psen});
            chk("R9 hi_port", hi_port, e_hi);
            if (k == 4) drive_flags(~v); // R10: mid-cycle flag changes must not matter
        end
        @(negedge clk);
    endtask

    // Called at a falling edge; returns at a falling edge with sys_rst high.
    task automatic do_reset();
        rst_pin = 1'b1;
        for (int i = 1; i <= 24; i++) begin
            @(posedge clk); #1;
            chk("R11 qualify", {7'b0, sys_rst}, {7'b0, i == 24});
        end
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk("R11 held", {7'b0, sys_rst}, 8'h01);
            chk("R11 ale parked", {7'b0, ale}, 8'h01);
            chk("R11 psen parked", {7'b0, psen_n}, 8'h01);
            chk("R11 no cyc_first", {7'b0, cyc_first}, 8'h00);
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R12: short pulse of 23 edges is ignored
        rst_pin = 1'b1;
        for (int i = 0; i < 23; i++) begin
            @(posedge clk); #1;
            chk("R12 short pulse", {7'b0, sys_rst}, 8'h00);
        end
        @(negedge clk);
        rst_pin = 1'b0;
        @(negedge clk);
        do_reset();
        rst_pin = 1'b0;
        for (int j = 0; j < NV; j++) run_cycle(VT[j]);
        // Back-to-back data moves, then a reset in mid-run and recovery
        run_cycle(VT[3]);
        run_cycle(VT[2]);
        do_reset();
        rst_pin = 1'b0;
        run_cycle(VT[5]);
        run_cycle(VT[0]);
        run_cycle(VT[9]);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule